// File: doc/BRIEF.md
# Rate-Half Convolutional Encoder with Optional 2/3 Puncturing

This block turns a serial stream of message bits into a protected coded bit stream. Each message bit accepted on the input stream moves a four-state encoder one step. The encoder keeps the two previous message bits as its memory. Each step forms a two-bit branch word from the new bit and that memory, and the word leaves the block one bit at a time on the output stream. A frame ends with a beat that carries the last flag. After that beat the encoder adds two zero tail steps by itself, so every frame starts and ends in the all-zero state.

A mode pin selects one of two output rates. With the pin low, both coded bits of every step are sent, which gives rate 1/2. With the pin high, the second coded bit of every other step is dropped, so each pair of message bits yields three coded bits. Both streams use valid/ready handshakes. An input beat transfers on a clock edge where `in_valid` and `in_ready` are both high. An output bit transfers on an edge where `out_valid` and `out_ready` are both high. `in_ready` depends combinationally on `out_ready`. While `out_ready` is low, the pending output bit is held steady and no new input is taken.

Top module: `conv_punct_enc`

## Requirements
- R1: While reset is asserted and in the cycle after it is released, `out_valid` is low and `in_ready` is high. The encoder memory holds zero.
- R2: For input bit b, previous bit p and oldest bit o, the first coded bit is b^p^o (taps 111) and the second is b^o (taps 101). The first coded bit leaves the block before the second.
- R3: The encoder memory always holds the two most recent encoded bits, tail bits included. Every frame begins from the all-zero memory.
- R4: An accepted beat with `in_last` high is followed by two encoder steps with input 0. `in_ready` is low from the cycle after that beat until both tail words have entered the output buffer.
- R5: With `punct_en` low, a frame of L message bits produces exactly 2(L+2) output bits.
- R6: With `punct_en` high, encoder steps are numbered from 0 within each frame, tail steps included. Even steps emit both coded bits and odd steps emit only the first. A frame of L message bits then yields (L+2)+ceil((L+2)/2) bits. Step numbering restarts at 0 for every frame.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_bit` stays unchanged on the next cycle.
- R8: Output appears only as a result of accepted input. When the block is idle and no beat is accepted, `out_valid` stays low.
- R9: `punct_en` must be held constant from the first beat of a frame until the last bit of that frame has left the block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| punct_en | input | 1 | 1 selects rate 2/3 puncturing, 0 selects rate 1/2 |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Block can take an input beat |
| in_bit | input | 1 | Message bit |
| in_last | input | 1 | Beat is the final message bit of the frame |
| out_valid | output | 1 | Coded bit present |
| out_ready | input | 1 | Sink takes the coded bit |
| out_bit | output | 1 | Coded bit |

## Verification
An accepted input beat loads its branch word into the output register on the same edge. The first coded bit of that word is therefore visible one cycle after the handshake. The second coded bit follows on the cycle after the sink takes the first. The bench drives inputs on falling edges and samples handshakes one time unit later. Each recorded bit is the one that transfers on the next rising edge, so no check depends on ordering at that edge. `in_ready` is checked on the falling edge right after the last beat, which is the first cycle in which the tail must stall input. The comparison of a frame's bit count waits until the expected number of bits has arrived and then allows six idle cycles, so a surplus bit would be counted.

// File: rtl/conv_enc_pkg.sv
package conv_enc_pkg;
  localparam int unsigned CONSTRAINT_LEN = 3;
  localparam int unsigned MEM_BITS       = CONSTRAINT_LEN - 1;
  localparam int unsigned CODE_BITS      = 2;
  localparam int unsigned CNT_W          = $clog2(CODE_BITS + 1);

  typedef struct packed {
    logic [CODE_BITS-1:0] bits;  // bits[0] leaves first
    logic [CNT_W-1:0]     count; // number of valid bits in bits
  } code_word_t;
endpackage

// File: rtl/conv_enc_core.sv
module conv_enc_core #(
  parameter int unsigned K    = 3,
  parameter int unsigned NOUT = 2,
  parameter logic [NOUT*K-1:0] GENS = {3'b101, 3'b111}
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            step,
  input  logic            din,
  output logic [NOUT-1:0] code
);
  localparam int unsigned MEM = K - 1;

  // hist[MEM-1] is the previous bit, hist[0] the oldest
  logic [MEM-1:0] hist_q;
  logic [K-1:0]   window;

  assign window = {din, hist_q};

  generate
    for (genvar j = 0; j < NOUT; j++) begin : g_tap
      assign code[j] = ^(window & GENS[j*K +: K]);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) hist_q <= '0;
    else if (step) hist_q <= window[K-1:1];
  end
endmodule

// File: rtl/conv_enc_punct.sv
module conv_enc_punct
  import conv_enc_pkg::*;
#(
  parameter logic [2*CODE_BITS-1:0] KEEP_PAT = 4'b0111
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 step,
  input  logic                 frame_end,
  input  logic                 punct_en,
  input  logic [CODE_BITS-1:0] code,
  output code_word_t           word
);
  logic                 phase_q;
  logic [CODE_BITS-1:0] keep;

  always_comb begin
    keep = punct_en ? KEEP_PAT[phase_q*CODE_BITS +: CODE_BITS] : '1;
    word.bits  = '0;
    word.count = '0;
    unique case (keep)
      2'b11: begin word.bits = code;               word.count = 2'd2; end
      2'b01: begin word.bits = {1'b0, code[0]};    word.count = 2'd1; end
      2'b10: begin word.bits = {1'b0, code[1]};    word.count = 2'd1; end
      default: begin word.bits = '0;               word.count = 2'd0; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) phase_q <= 1'b0;
    else if (step) phase_q <= frame_end ? 1'b0 : ~phase_q;
  end
endmodule

// File: rtl/conv_enc_serial.sv
module conv_enc_serial
  import conv_enc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  code_word_t word,
  output logic       can_load,
  output logic       out_valid,
  input  logic       out_ready,
  output logic       out_bit
);
  logic [CODE_BITS-1:0] buf_q;
  logic [CNT_W-1:0]     cnt_q;
  logic                 pop;

  assign out_valid = (cnt_q != '0);
  assign out_bit   = buf_q[0];
  assign pop       = out_valid && out_ready;
  assign can_load  = (cnt_q == '0) || ((cnt_q == CNT_W'(1)) && out_ready);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      buf_q <= '0;
      cnt_q <= '0;
    end else if (load) begin
      buf_q <= word.bits;
      cnt_q <= word.count;
    end else if (pop) begin
      buf_q <= buf_q >> 1;
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end
endmodule

// File: rtl/conv_punct_enc.sv
module conv_punct_enc
  import conv_enc_pkg::*;
#(
  parameter logic [CODE_BITS*CONSTRAINT_LEN-1:0] GENS     = {3'b101, 3'b111},
  parameter logic [2*CODE_BITS-1:0]              KEEP_PAT = 4'b0111
) (
  input  logic clk,
  input  logic rst_n,
  input  logic punct_en,
  input  logic in_valid,
  output logic in_ready,
  input  logic in_bit,
  input  logic in_last,
  output logic out_valid,
  input  logic out_ready,
  output logic out_bit
);
  localparam int unsigned TAIL_W = $clog2(MEM_BITS + 1);

  logic [TAIL_W-1:0]    tail_left_q;
  logic                 in_tail;
  logic                 can_load;
  logic                 step;
  logic                 frame_end;
  logic                 enc_in;
  logic [CODE_BITS-1:0] code;
  code_word_t           word;

  assign in_tail   = (tail_left_q != '0);
  assign in_ready  = !in_tail && can_load;
  assign step      = can_load && (in_tail || in_valid);
  assign enc_in    = in_tail ? 1'b0 : in_bit;
  assign frame_end = in_tail && (tail_left_q == TAIL_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) tail_left_q <= '0;
    else if (step) begin
      if (in_tail) tail_left_q <= tail_left_q - TAIL_W'(1);
      else if (in_last) tail_left_q <= TAIL_W'(MEM_BITS);
    end
  end

  conv_enc_core #(
    .K    (CONSTRAINT_LEN),
    .NOUT (CODE_BITS),
    .GENS (GENS)
  ) u_core (
    .clk   (clk),
    .rst_n (rst_n),
    .step  (step),
    .din   (enc_in),
    .code  (code)
  );

  conv_enc_punct #(
    .KEEP_PAT (KEEP_PAT)
  ) u_punct (
    .clk       (clk),
    .rst_n     (rst_n),
    .step      (step),
    .frame_end (frame_end),
    .punct_en  (punct_en),
    .code      (code),
    .word      (word)
  );

  conv_enc_serial u_serial (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (step),
    .word      (word),
    .can_load  (can_load),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_bit   (out_bit)
  );
endmodule

// File: rtl/conv_punct_enc_chk.sv
module conv_punct_enc_chk (
  input logic clk,
  input logic rst_n,
  input logic in_valid,
  input logic in_ready,
  input logic in_last,
  input logic out_valid,
  input logic out_ready,
  input logic out_bit
);
  a_r1_reset_state: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!out_valid && in_ready));

  a_r7_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_bit)));

  a_r4_tail_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_last) |=> !in_ready);

  a_r8_no_spurious_out: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_valid && in_ready && !in_valid) |=> !out_valid);
endmodule

bind conv_punct_enc conv_punct_enc_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_last   (in_last),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_bit   (out_bit)
);

// File: tb/conv_punct_enc_test.sv
module conv_punct_enc_test;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_CYCLES = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic punct_en = 1'b0;
  logic in_valid = 1'b0;
  logic in_bit = 1'b0;
  logic in_last = 1'b0;
  logic out_ready = 1'b1;
  logic in_ready, out_valid, out_bit;

  int checks = 0;
  int errors = 0;
  int pass_no = 0;
  int ocnt = 0;
  logic obuf [0:63];
  logic ebuf [0:63];
  logic [15:0] rdy_lfsr = 16'hACE1;
  logic [15:0] gap_lfsr = 16'h1D2B;

  always #(CLK_PERIOD/2) clk = ~clk;

  conv_punct_enc uut (
    .clk(clk), .rst_n(rst_n), .punct_en(punct_en),
    .in_valid(in_valid), .in_ready(in_ready), .in_bit(in_bit), .in_last(in_last),
    .out_valid(out_valid), .out_ready(out_ready), .out_bit(out_bit)
  );

  // sink back-pressure
  initial forever begin
    @(negedge clk);
    rdy_lfsr = {rdy_lfsr[14:0], rdy_lfsr[15] ^ rdy_lfsr[13] ^ rdy_lfsr[12] ^ rdy_lfsr[10]};
    out_ready = (pass_no == 0) ? 1'b1 : rdy_lfsr[0];
  end

  // output monitor: records the bit that transfers on the next rising edge
  initial forever begin
    @(negedge clk);
    #1;
    if (rst_n && out_valid && out_ready && ocnt < 64) begin
      obuf[ocnt] = out_bit;
      ocnt++;
    end
  end

  initial begin : watchdog
    repeat (MAX_CYCLES) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run exceeded %0d cycles (actual hung, expected done)", MAX_CYCLES);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic send_frame(input int len, input int msg, input bit mode);
    int nexp = 0;
    int guard = 0;
    int first_bad = -1;
    logic s_prev = 1'b0;
    logic s_old = 1'b0;
    // reference model: R2 taps, R3 memory, R4 tail, R5/R6 puncturing
    for (int i = 0; i < len + 2; i++) begin
      logic b;
      b = (i < len) ? msg[i] : 1'b0;
      ebuf[nexp] = b ^ s_prev ^ s_old; nexp++;
      if (!mode || (i % 2 == 0)) begin ebuf[nexp] = b ^ s_old; nexp++; end
      s_old = s_prev;
      s_prev = b;
    end
    @(negedge clk);
    punct_en = mode;
    ocnt = 0;
    for (int i = 0; i < len; i++) begin
      gap_lfsr = {gap_lfsr[14:0], gap_lfsr[15] ^ gap_lfsr[13] ^ gap_lfsr[12] ^ gap_lfsr[10]};
      if (pass_no != 0 && gap_lfsr[0] && gap_lfsr[1]) begin
        in_valid = 1'b0;
        @(negedge clk);
      end
      in_valid = 1'b1;
      in_bit   = msg[i];
      in_last  = (i == len - 1);
      #1;
      while (!in_ready) begin @(negedge clk); #1; end
      @(negedge clk);
    end
    in_valid = 1'b0;
    in_last  = 1'b0;
    #1;
    check(in_ready == 1'b0, "R4 in_ready low after last beat", int'(in_ready), 0);
    while (ocnt < nexp && guard < 400) begin @(negedge clk); guard++; end
    repeat (6) @(negedge clk);
    #2;
    if (mode)
      check(ocnt == nexp, "R6 punctured bit count", ocnt, nexp);
    else
      check(ocnt == nexp, "R5 rate-half bit count", ocnt, nexp);
    for (int i = 0; i < nexp && i < ocnt; i++)
      if (first_bad < 0 && obuf[i] !== ebuf[i]) first_bad = i;
    check(first_bad < 0, mode ? "R2 R3 R6 coded bits (index of first mismatch)"
                              : "R2 R3 R5 coded bits (index of first mismatch)",
          first_bad, -1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check(out_valid == 1'b0, "R1 out_valid low in reset", int'(out_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    check(out_valid == 1'b0, "R1 out_valid low after reset", int'(out_valid), 0);
    check(in_ready == 1'b1, "R1 in_ready high after reset", int'(in_ready), 1);
    // R8: idle with no input must produce nothing
    repeat (5) @(negedge clk);
    #1;
    check(ocnt == 0 && out_valid == 1'b0, "R8 idle produces no output", ocnt, 0);
    // exhaustive sweep: both sink patterns, both modes, all messages up to length 5 (R9: mode fixed per frame)
    for (int p = 0; p < 2; p++) begin
      pass_no = p;
      for (int m = 0; m < 2; m++)
        for (int len = 1; len <= 5; len++)
          for (int msg = 0; msg < (1 << len); msg++)
            send_frame(len, msg, m[0]);
    end
    // R7 handled under random back-pressure; R8 again after all frames drained
    repeat (4) @(negedge clk);
    #1;
    check(out_valid == 1'b0, "R8 no output after drain", int'(out_valid), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule